// File: doc/BRIEF.md
# Two-Phase Partitioned Tag Lookup

This block does the tag lookup for one indexed set of a set-associative cache. It avoids reading every way's full stored tag. In the first phase it reads only the low `SPLIT_K` bits of each valid way in the selected set and compares them with the same bits of the incoming tag. In the second phase it reads and compares the remaining upper tag bits, but only for the ways that passed the first phase. A way hits when both parts match.

The tag store is a register array with one fill port. A fill writes a new tag into a chosen way and marks that way valid. Lookups use a valid/ready handshake and are fully pipelined, so the block accepts one request per cycle. Each response arrives two cycles after its request is accepted. The response carries the hit flag, the hit way in one-hot and binary form, and a multi-hit error flag. It also carries two activity counts: how many ways were read in each phase.

The defaults are a 40-bit tag, 16 ways, 8 sets and a split point of 4. Split points from 3 to 5 are the usual sweet spot.

Top module: `ptag_lookup`

## Requirements
- R1: `lowReadCnt` equals the number of valid ways in the requested set. Only those ways take part in the low-bit compare, which covers tag bits `[SPLIT_K-1:0]`.
- R2: `highReadCnt` equals the number of valid ways whose low `SPLIT_K` bits equal the request's low bits. Only those ways have their upper bits `[TAG_W-1:SPLIT_K]` compared.
- R3: `rspHit` is 1 exactly when some valid way matches the full request tag. `rspWayOneHot` has bit w set for the reported way. `rspWayBin` holds w as an unsigned binary number.
- R4: When no way passes the low-bit compare, the response is a miss with `highReadCnt` = 0, `rspWayOneHot` = 0 and `rspMultiHit` = 0.
- R5: An invalid way is never counted in either phase and never hits, whatever it holds.
- R6: `reqReady` is 1 from the first clock edge after reset is released. A request is accepted when `reqValid` and `reqReady` are both 1. `rspValid` is 1 exactly two cycles after each accepted request, and 0 at all other times.
- R7: A fill writes `fillTag` into way `fillWay` of set `fillSet` and sets that way valid. Lookups accepted after the fill's clock edge see the new tag.
- R8: When a fill and an accepted lookup target the same set in the same cycle, the lookup's result and counts use the set's contents from before the fill.
- R9: When more than one way fully matches, the lowest-numbered matching way is reported and `rspMultiHit` is 1. Otherwise `rspMultiHit` is 0.
- R10: Reset (active-low `rstN`) clears every valid bit. While reset is asserted, `reqReady` and `rspValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Lookup can be accepted |
| reqSet | input | $clog2(SETS) | Set index of the lookup |
| reqTag | input | TAG_W | Tag to look up |
| fillEn | input | 1 | Fill write enable |
| fillSet | input | $clog2(SETS) | Set index of the fill |
| fillWay | input | $clog2(WAYS) | Way to write |
| fillTag | input | TAG_W | Tag to store |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Full tag match found |
| rspWayOneHot | output | WAYS | Reported way, one-hot |
| rspWayBin | output | $clog2(WAYS) | Reported way, binary |
| rspMultiHit | output | 1 | More than one way fully matched |
| lowReadCnt | output | $clog2(WAYS+1) | Ways read in phase one |
| highReadCnt | output | $clog2(WAYS+1) | Ways read in phase two |

## Verification
The bench fills a set with tags whose low bits repeat every four ways. Several ways then pass the filter while only one matches in full. A design that skipped the gating, or gated on the wrong bits, would report a wrong `highReadCnt`. A lookup whose low bits match no way checks that the second phase is fully suppressed. A lookup whose low bits match but whose upper bits differ catches a design that declares a hit from the filter alone.

A fill to the very way being looked up in the acceptance cycle targets the one-cycle hazard between the phases. A design without the snapshot would compare the new upper bits and miss. Duplicated tags exercise lowest-way priority and the multi-hit flag. Partly filled sets show whether invalid ways leak into the counts. A long stretch of back-to-back random lookups and fills drawn from a small tag pool checks pipelining and ordering against the reference model.

// File: rtl/ptag_pkg.sv
package ptag_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // accept request: latch phase-one result
    logic resolve;   // run phase two and register the response
  } ptag_strobe_t;

endpackage

// File: rtl/ptag_ctrl.sv
module ptag_ctrl
  import ptag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         rspValid,
  output ptag_strobe_t strobe
);

  logic readyQ;
  logic stageOneValid;
  logic stageTwoValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ        <= 1'b0;
      stageOneValid <= 1'b0;
      stageTwoValid <= 1'b0;
    end else begin
      readyQ        <= 1'b1;
      stageOneValid <= reqValid && readyQ;
      stageTwoValid <= stageOneValid;
    end
  end

  assign reqReady       = readyQ;
  assign rspValid       = stageTwoValid;
  assign strobe.capture = reqValid && readyQ;
  assign strobe.resolve = stageOneValid;

endmodule

// File: rtl/ptag_dp.sv
module ptag_dp
  import ptag_pkg::*;
#(
  parameter int TAG_W   = 40,
  parameter int WAYS    = 16,
  parameter int SETS    = 8,
  parameter int SPLIT_K = 4,
  localparam int HI_W   = TAG_W - SPLIT_K,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CNT_W  = $clog2(WAYS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ptag_strobe_t       strobe,
  input  logic [SET_W-1:0]   reqSet,
  input  logic [TAG_W-1:0]   reqTag,
  input  logic               fillEn,
  input  logic [SET_W-1:0]   fillSet,
  input  logic [WAY_W-1:0]   fillWay,
  input  logic [TAG_W-1:0]   fillTag,
  output logic               rspHit,
  output logic [WAYS-1:0]    rspWayOneHot,
  output logic [WAY_W-1:0]   rspWayBin,
  output logic               rspMultiHit,
  output logic [CNT_W-1:0]   lowReadCnt,
  output logic [CNT_W-1:0]   highReadCnt
);

  // Tag store, split into separately read low and high slices.
  logic [SPLIT_K-1:0] lowArr  [SETS][WAYS];
  logic [HI_W-1:0]    highArr [SETS][WAYS];
  logic [WAYS-1:0]    validArr[SETS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) validArr[s] <= '0;
    end else if (fillEn) begin
      validArr[fillSet][fillWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      lowArr[fillSet][fillWay]  <= fillTag[SPLIT_K-1:0];
      highArr[fillSet][fillWay] <= fillTag[TAG_W-1:SPLIT_K];
    end
  end

  // Phase one: low-bit filter over the valid ways.
  logic [WAYS-1:0] validRow;
  logic [WAYS-1:0] lowHit;

  assign validRow = validArr[reqSet];

  for (genvar w = 0; w < WAYS; w++) begin : g_lowCmp
    assign lowHit[w] = validRow[w] && (lowArr[reqSet][w] == reqTag[SPLIT_K-1:0]);
  end

  logic [WAYS-1:0]  p1Mask;
  logic [SET_W-1:0] p1Set;
  logic [HI_W-1:0]  p1Upper;
  logic [CNT_W-1:0] p1LowCnt;
  logic             snapHit;
  logic [WAY_W-1:0] snapWay;
  logic [HI_W-1:0]  snapUpper;

  // A fill landing on the looked-up set in the accept cycle would change
  // the upper bits before phase two. Keep the old upper bits of that way.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Mask   <= '0;
      p1LowCnt <= '0;
      snapHit  <= 1'b0;
    end else if (strobe.capture) begin
      p1Mask   <= lowHit;
      p1LowCnt <= CNT_W'($countones(validRow));
      snapHit  <= fillEn && (fillSet == reqSet);
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      p1Set     <= reqSet;
      p1Upper   <= reqTag[TAG_W-1:SPLIT_K];
      snapWay   <= fillWay;
      snapUpper <= highArr[reqSet][fillWay];
    end
  end

  // Phase two: upper-bit compare, gated per way by the filter result.
  logic [HI_W-1:0] storedHigh [WAYS];
  logic [WAYS-1:0] fullHit;

  for (genvar w = 0; w < WAYS; w++) begin : g_highCmp
    always_comb begin
      if (!p1Mask[w])                              storedHigh[w] = '0;
      else if (snapHit && (snapWay == WAY_W'(w)))  storedHigh[w] = snapUpper;
      else                                         storedHigh[w] = highArr[p1Set][w];
    end
    assign fullHit[w] = p1Mask[w] && (storedHigh[w] == p1Upper);
  end

  // Lowest-way priority
  logic [WAYS-1:0]  firstHit;
  logic [WAY_W-1:0] firstBin;

  assign firstHit = fullHit & (~fullHit + WAYS'(1));

  always_comb begin
    firstBin = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (fullHit[i]) firstBin = WAY_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit       <= 1'b0;
      rspWayOneHot <= '0;
      rspWayBin    <= '0;
      rspMultiHit  <= 1'b0;
      lowReadCnt   <= '0;
      highReadCnt  <= '0;
    end else if (strobe.resolve) begin
      rspHit       <= |fullHit;
      rspWayOneHot <= firstHit;
      rspWayBin    <= firstBin;
      rspMultiHit  <= ($countones(fullHit) > 1);
      lowReadCnt   <= p1LowCnt;
      highReadCnt  <= CNT_W'($countones(p1Mask));
    end
  end

endmodule

// File: rtl/ptag_lookup.sv
module ptag_lookup
  import ptag_pkg::*;
#(
  parameter int TAG_W   = 40,
  parameter int WAYS    = 16,
  parameter int SETS    = 8,
  parameter int SPLIT_K = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CNT_W  = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [SET_W-1:0] reqSet,
  input  logic [TAG_W-1:0] reqTag,
  input  logic             fillEn,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic [TAG_W-1:0] fillTag,
  output logic             rspValid,
  output logic             rspHit,
  output logic [WAYS-1:0]  rspWayOneHot,
  output logic [WAY_W-1:0] rspWayBin,
  output logic             rspMultiHit,
  output logic [CNT_W-1:0] lowReadCnt,
  output logic [CNT_W-1:0] highReadCnt
);

  ptag_strobe_t strobe;

  ptag_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  ptag_dp #(
    .TAG_W   (TAG_W),
    .WAYS    (WAYS),
    .SETS    (SETS),
    .SPLIT_K (SPLIT_K)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqSet       (reqSet),
    .reqTag       (reqTag),
    .fillEn       (fillEn),
    .fillSet      (fillSet),
    .fillWay      (fillWay),
    .fillTag      (fillTag),
    .rspHit       (rspHit),
    .rspWayOneHot (rspWayOneHot),
    .rspWayBin    (rspWayBin),
    .rspMultiHit  (rspMultiHit),
    .lowReadCnt   (lowReadCnt),
    .highReadCnt  (highReadCnt)
  );

endmodule

// File: rtl/ptag_lookup_chk.sv
module ptag_lookup_chk #(
  parameter int WAYS    = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int CNT_W  = $clog2(WAYS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspHit,
  input logic [WAYS-1:0]  rspWayOneHot,
  input logic [WAY_W-1:0] rspWayBin,
  input logic             rspMultiHit,
  input logic [CNT_W-1:0] lowReadCnt,
  input logic [CNT_W-1:0] highReadCnt
);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady, 2)); // R6

  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ##1 rspValid); // R6

  AST_WAY_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot0(rspWayOneHot)); // R3

  AST_HIT_WAY_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspWayOneHot[rspWayBin] && $countones(rspWayOneHot) == 1)); // R3

  AST_HIGH_WITHIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (highReadCnt <= lowReadCnt)); // R2

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (lowReadCnt <= CNT_W'(WAYS))); // R1

  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspWayOneHot == '0 && !rspMultiHit)); // R4

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMultiHit) |-> (rspHit && highReadCnt >= CNT_W'(2))); // R9

  AST_HIT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (highReadCnt != '0)); // R4

endmodule

bind ptag_lookup ptag_lookup_chk #(.WAYS(WAYS)) i_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .rspValid     (rspValid),
  .rspHit       (rspHit),
  .rspWayOneHot (rspWayOneHot),
  .rspWayBin    (rspWayBin),
  .rspMultiHit  (rspMultiHit),
  .lowReadCnt   (lowReadCnt),
  .highReadCnt  (highReadCnt)
);

// File: tb/test_ptag_lookup.sv
module test_ptag_lookup;

  localparam int TAG_W = 40;
  localparam int WAYS  = 16;
  localparam int SETS  = 8;
  localparam int K     = 4;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(WAYS + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [SET_W-1:0] reqSet = '0;
  logic [TAG_W-1:0] reqTag = '0;
  logic             fillEn = 1'b0;
  logic [SET_W-1:0] fillSet = '0;
  logic [WAY_W-1:0] fillWay = '0;
  logic [TAG_W-1:0] fillTag = '0;
  logic             rspValid, rspHit, rspMultiHit;
  logic [WAYS-1:0]  rspWayOneHot;
  logic [WAY_W-1:0] rspWayBin;
  logic [CNT_W-1:0] lowReadCnt, highReadCnt;

  always #2 clk = ~clk;

  ptag_lookup #(.TAG_W(TAG_W), .WAYS(WAYS), .SETS(SETS), .SPLIT_K(K)) i_ptag_lookup (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSet(reqSet), .reqTag(reqTag), .fillEn(fillEn), .fillSet(fillSet),
    .fillWay(fillWay), .fillTag(fillTag), .rspValid(rspValid), .rspHit(rspHit),
    .rspWayOneHot(rspWayOneHot), .rspWayBin(rspWayBin), .rspMultiHit(rspMultiHit),
    .lowReadCnt(lowReadCnt), .highReadCnt(highReadCnt)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Behavioural reference store
  logic [TAG_W-1:0] mTag [SETS][WAYS];
  bit               mVal [SETS][WAYS];

  typedef struct {
    bit    valid;
    bit    hit;
    int    way;
    bit    multi;
    int    lowCnt;
    int    highCnt;
    string tag;
  } exp_t;

  exp_t e0, e1, e2;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t predict(input int s, input logic [TAG_W-1:0] t, input string tg);
    exp_t r;
    int hits = 0;
    r.valid = 1'b1; r.hit = 1'b0; r.way = -1; r.multi = 1'b0;
    r.lowCnt = 0; r.highCnt = 0; r.tag = tg;
    for (int w = 0; w < WAYS; w++) begin
      if (mVal[s][w]) begin
        r.lowCnt++;
        if (mTag[s][w] % (1 << K) == t % (1 << K)) begin
          r.highCnt++;
          if (mTag[s][w] == t) begin
            hits++;
            if (r.way < 0) r.way = w;
          end
        end
      end
    end
    r.hit = hits > 0;
    r.multi = hits > 1;
    return r;
  endfunction

  // One cycle: check the response due now, then drive the next inputs.
  task automatic cyc(input bit rv, input int rs, input logic [TAG_W-1:0] rt,
                     input bit fe, input int fs, input int fw,
                     input logic [TAG_W-1:0] ft, input string tg);
    @(negedge clk);
    e2 = e1; e1 = e0;
    check(rspValid == e2.valid, "R6", "rspValid", longint'(rspValid), longint'(e2.valid));
    if (e2.valid && rspValid) begin
      check(rspHit == e2.hit, e2.tag, "hit (R3)", longint'(rspHit), longint'(e2.hit));
      if (e2.hit) begin
        check(int'(rspWayBin) == e2.way, e2.tag, "wayBin (R3)", longint'(rspWayBin), longint'(e2.way));
        check(rspWayOneHot == (WAYS'(1) << e2.way), e2.tag, "wayOneHot (R3)",
              longint'(rspWayOneHot), longint'(WAYS'(1) << e2.way));
      end else begin
        check(rspWayOneHot == '0, e2.tag, "wayOneHot miss (R4)", longint'(rspWayOneHot), 0);
      end
      check(rspMultiHit == e2.multi, e2.tag, "multi (R9)", longint'(rspMultiHit), longint'(e2.multi));
      check(int'(lowReadCnt) == e2.lowCnt, e2.tag, "lowCnt (R1)", longint'(lowReadCnt), longint'(e2.lowCnt));
      check(int'(highReadCnt) == e2.highCnt, e2.tag, "highCnt (R2)", longint'(highReadCnt), longint'(e2.highCnt));
    end
    e0.valid = 1'b0;
    reqValid = rv; reqSet = SET_W'(rs); reqTag = rt;
    fillEn = fe; fillSet = SET_W'(fs); fillWay = WAY_W'(fw); fillTag = ft;
    if (rv) begin
      check(reqReady == 1'b1, "R6", "reqReady", longint'(reqReady), 1);
      e0 = predict(rs, rt, tg);   // old contents: R8
    end
    if (fe) begin
      mTag[fs][fw] = ft;
      mVal[fs][fw] = 1'b1;
    end
  endtask

  task automatic idle();
    cyc(1'b0, 0, '0, 1'b0, 0, 0, '0, "");
  endtask

  task automatic fill(input int s, input int w, input logic [TAG_W-1:0] t);
    cyc(1'b0, 0, '0, 1'b1, s, w, t, "R7");
  endtask

  task automatic look(input int s, input logic [TAG_W-1:0] t, input string tg);
    cyc(1'b1, s, t, 1'b0, 0, 0, '0, tg);
  endtask

  function automatic logic [TAG_W-1:0] mk(input int up, input int lo);
    return (TAG_W'(up) << K) | TAG_W'(lo);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    e0 = '{default: 0, tag: ""}; e1 = e0; e2 = e0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin mVal[s][w] = 1'b0; mTag[s][w] = '0; end

    // R10: reset state
    repeat (3) @(negedge clk);
    check(reqReady == 1'b0, "R10", "reqReady in reset", longint'(reqReady), 0);
    check(rspValid == 1'b0, "R10", "rspValid in reset", longint'(rspValid), 0);
    rstN = 1'b1;
    idle();

    // R10 / R5: cold lookups see nothing valid
    for (int s = 0; s < SETS; s++) look(s, mk(5, 3), "R10");

    // R2: set 2, low bits repeat every four ways
    for (int w = 0; w < WAYS; w++) fill(2, w, mk(100 + w, w % 4));
    look(2, mk(105, 1), "R2");
    look(2, mk(112, 0), "R3");
    look(2, mk(999, 2), "R2");     // filter passes, upper mismatch
    look(2, mk(105, 9), "R4");     // no low match
    idle(); idle();

    // R5: partly filled set
    fill(3, 3, mk(7, 6));
    fill(3, 7, mk(8, 6));
    look(3, mk(8, 6), "R5");
    look(3, mk(0, 0), "R5");       // invalid ways hold zero tags
    idle(); idle();

    // R9: duplicated tag
    fill(4, 9, mk(42, 5));
    fill(4, 6, mk(42, 5));
    fill(4, 2, mk(43, 5));
    look(4, mk(42, 5), "R9");
    look(4, mk(43, 5), "R9");
    idle(); idle();

    // R8: fill to the looked-up way in the accept cycle
    cyc(1'b1, 2, mk(105, 1), 1'b1, 2, 5, mk(555, 1), "R8");
    look(2, mk(105, 1), "R7");
    look(2, mk(555, 1), "R7");
    // R8: fill that validates a new way in the accept cycle
    cyc(1'b1, 3, mk(9, 6), 1'b1, 3, 11, mk(9, 6), "R8");
    look(3, mk(9, 6), "R7");
    idle(); idle();

    // Mixed back-to-back traffic from a small pool
    for (int i = 0; i < 400; i++) begin
      int s  = $urandom_range(SETS - 1, 0);
      int fs = $urandom_range(SETS - 1, 0);
      cyc($urandom_range(3, 0) != 0, s, mk($urandom_range(3, 0), $urandom_range(3, 0)),
          $urandom_range(2, 0) == 0, fs, $urandom_range(WAYS - 1, 0),
          mk($urandom_range(3, 0), $urandom_range(3, 0)), "R3");
    end
    idle(); idle(); idle();
    finish_run();
  end

endmodule